// File: doc/BRIEF.md
# Performance Event Counter Bank

The block keeps four 32-bit event counters for a processor core. Once per update the core reports three amounts: how many processor cycles went by, how many load/store instructions completed, and how many floating-point instructions completed. Each amount is a small integer, so one update can add more than one. Each counter has its own select code. The code chooses which of these amounts the counter accumulates, or whether it accumulates nothing. The select codes and two interrupt enables sit in two control registers. The first control register serves counters 1 and 2. The second serves counters 3 and 4.

When an enabled counter has its most significant bit set, the block raises a performance-monitor exception request. Counter 1 has an enable of its own. Counters 2 to 4 share a second enable. The request is held as a sticky pending flag until the exception logic acknowledges it. Software reaches the counters and the control registers through a single-cycle write port and a combinational read port.

Top module: `pmc_unit`

## Requirements
- R1: After reset, all four counters and both control registers read 0, and `irq_pend` is 0.
- R2: A select code of 0, or any code that is not defined for that counter, leaves the counter unchanged by an update.
- R3: Select code 1 adds `cyc_cnt` to the counter on any of the four counters.
- R4: Select code 11 adds `ls_cnt` on counter 2 and `fp_cnt` on counter 3. The same code leaves counters 1 and 4 unchanged.
- R5: Counters wrap modulo 2^32, so 0xFFFFFFFE plus 5 gives 0x00000003.
- R6: A software write to a counter in the same cycle as an update stores the written value, and the increment is dropped.
- R7: When `upd_valid` is 0, no counter changes, whatever the amount inputs carry.
- R8: The request condition is true when counter 1 has bit 31 set and its own enable (control A bit 12) is set. It is also true when any of counters 2 to 4 has bit 31 set and the shared enable (control A bit 13) is set. Neither enable covers the other group.
- R9: `irq_pend` is set one cycle after the request condition becomes true. It then stays set until a cycle with `irq_ack` high in which the condition is false. After that cycle it is clear.
- R10: The register map is as follows. Addresses 0 to 3 hold counters 1 to 4. Address 4 is control A: select for counter 1 in [5:0], select for counter 2 in [11:6], and the enables in bits 12 and 13. Address 5 is control B: select for counter 3 in [5:0] and select for counter 4 in [11:6]. Unused bits read 0, and addresses 6 and 7 read 0.
- R11: A counter update or a register write is visible on `rd_data` in the cycle after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | The amount inputs are valid this cycle |
| cyc_cnt | input | 8 | Processor cycles elapsed in this update |
| ls_cnt | input | 8 | Load/store instructions completed in this update |
| fp_cnt | input | 8 | Floating-point instructions completed in this update |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge from the exception logic |
| irq_pend | output | 1 | Pending performance-monitor exception request |

## Verification
Every one of the 64 select codes is swept on each of the four counters. Each trial uses an update whose cycle, load/store and floating-point amounts are all different. This shows which source a code routes to, and separates a code that is defined only on a particular counter from a code that does nothing. Counters that start near the top of the range exercise the wrap. A write that lands in the same cycle as an update shows whether the write or the increment wins. For the interrupt, bit 31 is set on each counter in turn, once under each enable. This separates the dedicated enable from the shared one. Acknowledges are given both while the condition still holds and after it has cleared, which shows whether the pending flag is sticky.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NUM_CNT = 4;
  localparam int SEL_W   = 6;
  localparam int ADDR_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_NONE   = 6'd0,
    EV_CYCLES = 6'd1,
    EV_UNIT   = 6'd11
  } pmc_event_e;

  localparam logic [ADDR_W-1:0] A_CNT0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRLA = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRLB = 3'd5;

  localparam int BIT_EN_FIRST  = 2 * SEL_W;
  localparam int BIT_EN_SHARED = 2 * SEL_W + 1;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 8,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [SEL_W-1:0] sel,
  input  logic [INC_W-1:0] cyc_cnt,
  input  logic [INC_W-1:0] ls_cnt,
  input  logic [INC_W-1:0] fp_cnt,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inc_event
);
  // The amount this counter takes from one update, given its select code.
  function automatic logic [INC_W-1:0] pick_amount(
    input logic [SEL_W-1:0] code,
    input logic [INC_W-1:0] cyc,
    input logic [INC_W-1:0] ls,
    input logic [INC_W-1:0] fp
  );
    logic [INC_W-1:0] amt;
    amt = '0;
    if (code == EV_CYCLES) begin
      amt = cyc;
    end else if (code == EV_UNIT) begin
      if (IDX == 1) amt = ls;
      else if (IDX == 2) amt = fp;
    end
    return amt;
  endfunction

  // Modulo-2^CNT_W accumulate.
  function automatic logic [CNT_W-1:0] wrap_add(
    input logic [CNT_W-1:0] base,
    input logic [INC_W-1:0] amt
  );
    return base + {{(CNT_W-INC_W){1'b0}}, amt};
  endfunction

  logic [INC_W-1:0] amount;
  logic [CNT_W-1:0] cnt_d;

  assign amount    = pick_amount(sel, cyc_cnt, ls_cnt, fp_cnt);
  assign inc_event = upd_valid && (amount != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_hit)         cnt_d = wr_data;
    else if (upd_valid) cnt_d = wrap_add(cnt_q, amount);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_arr [NUM_CNT],
  output logic              en_first,
  output logic              en_shared,
  output logic [DATA_W-1:0] ctrla_rd,
  output logic [DATA_W-1:0] ctrlb_rd
);
  localparam int A_BITS = 2 * SEL_W + 2;
  localparam int B_BITS = 2 * SEL_W;

  logic [A_BITS-1:0] ctrla_q;
  logic [B_BITS-1:0] ctrlb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRLA) ctrla_q <= wr_data[A_BITS-1:0];
      if (wr_addr == A_CTRLB) ctrlb_q <= wr_data[B_BITS-1:0];
    end
  end

  assign sel_arr[0] = ctrla_q[SEL_W-1:0];
  assign sel_arr[1] = ctrla_q[2*SEL_W-1:SEL_W];
  assign sel_arr[2] = ctrlb_q[SEL_W-1:0];
  assign sel_arr[3] = ctrlb_q[2*SEL_W-1:SEL_W];
  assign en_first   = ctrla_q[BIT_EN_FIRST];
  assign en_shared  = ctrla_q[BIT_EN_SHARED];
  assign ctrla_rd   = {{(DATA_W-A_BITS){1'b0}}, ctrla_q};
  assign ctrlb_rd   = {{(DATA_W-B_BITS){1'b0}}, ctrlb_q};
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] msb,
  input  logic               en_first,
  input  logic               en_shared,
  input  logic               irq_ack,
  output logic               irq_cond,
  output logic               irq_pend
);
  // Counter 0 answers to its own enable, the rest to the shared one.
  function automatic logic request(
    input logic [NUM_CNT-1:0] top,
    input logic               ef,
    input logic               es
  );
    return (ef && top[0]) || (es && (|top[NUM_CNT-1:1]));
  endfunction

  assign irq_cond = request(msb, en_first, en_shared);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend <= 1'b0;
    else        irq_pend <= irq_cond || (irq_pend && !irq_ack);
  end
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [INC_W-1:0]  cyc_cnt,
  input  logic [INC_W-1:0]  ls_cnt,
  input  logic [INC_W-1:0]  fp_cnt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              irq_ack,
  output logic              irq_pend
);
  logic [SEL_W-1:0]         sel_arr [NUM_CNT];
  logic [CNT_W-1:0]         cnt_q   [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       cnt_msb;
  logic [NUM_CNT-1:0]       cnt_wr_hit;
  logic [NUM_CNT-1:0]       cnt_inc_event;
  logic                     en_first;
  logic                     en_shared;
  logic                     irq_cond;
  logic [CNT_W-1:0]         ctrla_rd;
  logic [CNT_W-1:0]         ctrlb_rd;

  pmc_ctrl #(.DATA_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sel_arr   (sel_arr),
    .en_first  (en_first),
    .en_shared (en_shared),
    .ctrla_rd  (ctrla_rd),
    .ctrlb_rd  (ctrlb_rd)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_wr_hit[i] = wr_en && (wr_addr == A_CNT0 + ADDR_W'(i));

    pmc_counter #(.CNT_W(CNT_W), .INC_W(INC_W), .IDX(i)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (upd_valid),
      .sel       (sel_arr[i]),
      .cyc_cnt   (cyc_cnt),
      .ls_cnt    (ls_cnt),
      .fp_cnt    (fp_cnt),
      .wr_hit    (cnt_wr_hit[i]),
      .wr_data   (wr_data),
      .cnt_q     (cnt_q[i]),
      .inc_event (cnt_inc_event[i])
    );

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    assign cnt_msb[i] = cnt_q[i][CNT_W-1];
  end

  pmc_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .msb       (cnt_msb),
    .en_first  (en_first),
    .en_shared (en_shared),
    .irq_ack   (irq_ack),
    .irq_cond  (irq_cond),
    .irq_pend  (irq_pend)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0:    rd_data = cnt_q[0];
      3'd1:    rd_data = cnt_q[1];
      3'd2:    rd_data = cnt_q[2];
      3'd3:    rd_data = cnt_q[3];
      A_CTRLA: rd_data = ctrla_rd;
      A_CTRLB: rd_data = ctrlb_rd;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int INC_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     upd_valid,
  input logic [INC_W-1:0]         cyc_cnt,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [CNT_W-1:0]         wr_data,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [NUM_CNT-1:0]       cnt_inc_event,
  input logic [SEL_W-1:0]         sel0,
  input logic                     en_first,
  input logic                     en_shared,
  input logic                     irq_cond,
  input logic                     irq_ack,
  input logic                     irq_pend
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (cnt_flat == '0) && !irq_pend);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !wr_en) |=> $stable(cnt_flat));

  a_r7_no_event_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (cnt_inc_event == '0));

  a_r3_cycles_first: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !wr_en && sel0 == EV_CYCLES) |=>
      cnt_flat[CNT_W-1:0] == $past(cnt_flat[CNT_W-1:0]) + CNT_W'($past(cyc_cnt)));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT0) |=> cnt_flat[CNT_W-1:0] == $past(wr_data));

  a_r8_no_enable_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_first && !en_shared) |-> !irq_cond);

  a_r9_set_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cond |=> irq_pend);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && irq_ack && !irq_cond) |=> !irq_pend);
endmodule

bind pmc_unit pmc_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .upd_valid     (upd_valid),
  .cyc_cnt       (cyc_cnt),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .cnt_flat      (cnt_flat),
  .cnt_inc_event (cnt_inc_event),
  .sel0          (sel_arr[0]),
  .en_first      (en_first),
  .en_shared     (en_shared),
  .irq_cond      (irq_cond),
  .irq_ack       (irq_ack),
  .irq_pend      (irq_pend)
);

// File: tb/test_pmc_unit.sv
`timescale 1ns/1ps
module test_pmc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [7:0]  cyc_cnt = '0, ls_cnt = '0, fp_cnt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_ack = 1'b0;
  logic        irq_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmc_unit i_pmc_unit (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
    .cyc_cnt(cyc_cnt), .ls_cnt(ls_cnt), .fp_cnt(fp_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq_pend(irq_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd(input logic [7:0] c, input logic [7:0] l, input logic [7:0] f);
    @(negedge clk);
    upd_valid = 1'b1; cyc_cnt = c; ls_cnt = l; fp_cnt = f;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // Independent model of what one update adds to counter idx.
  function automatic logic [31:0] model_amt(input int idx, input int code,
      input logic [7:0] c, input logic [7:0] l, input logic [7:0] f);
    if (code == 1) return {24'd0, c};
    if (code == 11 && idx == 1) return {24'd0, l};
    if (code == 11 && idx == 2) return {24'd0, f};
    return 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 32'd0);
    end
    chk("R1 reset pend", {31'd0, irq_pend}, 32'd0);

    // R10 readback masking
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R10 ctrlA mask", v, 32'h0000_3FFF);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R10 ctrlB mask", v, 32'h0000_0FFF);
    rd(3'd6, v); chk("R10 addr6", v, 32'd0);
    rd(3'd7, v); chk("R10 addr7", v, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd0);

    // R2 R3 R4 R11: sweep all select codes on every counter
    for (int c = 0; c < 4; c++) begin
      for (int code = 0; code < 64; code++) begin
        logic [31:0] base;
        logic [31:0] sa, sb;
        base = 32'h0001_0000 * (code + 1) + 32'(c);
        sa = (c < 2) ? (32'(code) << (6 * c)) : 32'd0;
        sb = (c >= 2) ? (32'(code) << (6 * (c - 2))) : 32'd0;
        wr(3'd4, sa);
        wr(3'd5, sb);
        wr(3'(c), base);
        upd(8'd3, 8'd5, 8'd7);
        rd(3'(c), v);
        if (code == 1)       chk("R3 cycles code", v, base + model_amt(c, code, 8'd3, 8'd5, 8'd7));
        else if (code == 11) chk("R4 unit code", v, base + model_amt(c, code, 8'd3, 8'd5, 8'd7));
        else                 chk("R2 no-op code", v, base + model_amt(c, code, 8'd3, 8'd5, 8'd7));
      end
    end

    // R5 wrap
    wr(3'd5, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd0, 32'hFFFF_FFFE);
    upd(8'd5, 8'd0, 8'd0);
    rd(3'd0, v); chk("R5 wrap small", v, 32'h0000_0003);
    wr(3'd0, 32'hFFFF_FF80);
    upd(8'd255, 8'd0, 8'd0);
    rd(3'd0, v); chk("R5 wrap max", v, 32'h0000_007F);
    wr(3'd4, 32'd11 << 6);
    wr(3'd1, 32'hFFFF_FFFF);
    upd(8'd0, 8'd2, 8'd0);
    rd(3'd1, v); chk("R5 wrap ls", v, 32'h0000_0001);

    // R6 write wins over update
    wr(3'd4, 32'd1);
    wr(3'd0, 32'd100);
    @(negedge clk);
    upd_valid = 1'b1; cyc_cnt = 8'd9;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0000_1234;
    @(negedge clk);
    upd_valid = 1'b0; wr_en = 1'b0;
    rd(3'd0, v); chk("R6 write priority", v, 32'h0000_1234);

    // R7 no change without upd_valid
    @(negedge clk);
    cyc_cnt = 8'd9; ls_cnt = 8'd9; fp_cnt = 8'd9;
    idle(3);
    rd(3'd0, v); chk("R7 idle hold", v, 32'h0000_1234);
    // R11 latency: visible right after the performing edge
    upd(8'd6, 8'd0, 8'd0);
    rd(3'd0, v); chk("R11 one-cycle visible", v, 32'h0000_123A);

    // R8 R9 interrupt
    wr(3'd4, 32'd0);
    for (int a = 0; a < 4; a++) wr(3'(a), 32'd0);
    idle(2); ack(); idle(1);
    chk("R9 clear baseline", {31'd0, irq_pend}, 32'd0);
    wr(3'd0, 32'h8000_0000);
    idle(2);
    chk("R8 no enable", {31'd0, irq_pend}, 32'd0);
    wr(3'd4, 32'h0000_2000);
    idle(2);
    chk("R8 shared not on counter1", {31'd0, irq_pend}, 32'd0);
    wr(3'd4, 32'h0000_1000);
    idle(2);
    chk("R8 counter1 own enable", {31'd0, irq_pend}, 32'd1);
    ack(); idle(1);
    chk("R9 ack with cond held", {31'd0, irq_pend}, 32'd1);
    wr(3'd0, 32'd0);
    idle(2);
    chk("R9 sticky after clear", {31'd0, irq_pend}, 32'd1);
    ack(); idle(1);
    chk("R9 ack clears", {31'd0, irq_pend}, 32'd0);

    for (int c = 1; c < 4; c++) begin
      wr(3'd4, 32'h0000_1000);
      wr(3'(c), 32'h8000_0000);
      idle(2);
      chk("R8 own enable not on others", {31'd0, irq_pend}, 32'd0);
      wr(3'd4, 32'h0000_2000);
      idle(2);
      chk("R8 shared enable", {31'd0, irq_pend}, 32'd1);
      wr(3'(c), 32'd0);
      idle(2);
      chk("R9 sticky shared", {31'd0, irq_pend}, 32'd1);
      ack(); idle(1);
      chk("R9 ack clears shared", {31'd0, irq_pend}, 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule